// File: doc/BRIEF.md
# Dual-Bank Coefficient IIR Loop Compensator

This block is the fixed-point compensator of a current control loop. Each accepted error sample passes first through a second-order recursive section, then through a first-order recursive section. The result is limited to the signed output word and drives the duty command of the pulse-width modulator. One accepted sample finishes in two clock edges: the second-order stage registers its result on the edge that accepts the strobe, and the first-order stage registers the output on the next edge.

The eight coefficients sit in two register banks. One bank feeds the arithmetic. Software writes the other bank, the shadow, through a simple write port at any time. A swap request exchanges the two roles. The exchange is held back until no sample is being accepted and none is in flight, so every sample is computed with a single coefficient set. The delay elements of both stages carry through a swap unchanged. An output bit reports which bank is in use.

Coefficients are signed with FRAC fractional bits. Coefficient addresses are 0 to b0, 1 to b1, 2 to b2, 3 to a1, 4 to a2, 5 to c0, 6 to c1 and 7 to d1.

Top module: `dbq_comp`

## Requirements
- R1: After reset, ctl_o is 0, ctl_vld_o is 0 and bank_sel_o is 0. Both banks are all zero and all delay elements are zero.
- R2: For each accepted sample x, the second-order stage computes w = sat(floor((b0*x + b1*x1 + b2*x2 - a1*w1 - a2*w2) / 2^FRAC)). Here x1 and x2 are the previous two accepted inputs, w1 and w2 are the previous two stage results, and sat clamps to the DW-bit signed range.
- R3: The first-order stage computes y = sat(floor((c0*w + c1*wp - d1*yp) / 2^FRAC)), where wp and yp are its previous input and output. A strobe sampled at edge E0 gives ctl_o = y with ctl_vld_o high for exactly one cycle after edge E1.
- R4: A write stores cfg_wdata_i at cfg_addr_i in the bank that is not in use at that edge. It has no effect on the outputs computed while that bank stays in the shadow role.
- R5: A swap request at an edge with no strobe and nothing in flight inverts bank_sel_o after that edge. Samples accepted afterwards use the newly selected bank.
- R6: A swap request that coincides with an accepted strobe, or arrives while a sample is in flight, is held pending. It takes effect at the first edge with nothing in flight and no new strobe, so that sample is computed wholly with the previous bank.
- R7: A swap leaves every delay element unchanged. The first sample after a swap uses the history built under the previous bank.
- R8: Both the second-order result and the final output saturate to the range -2^(DW-1) .. 2^(DW-1)-1 rather than wrapping.
- R9: A strobe that arrives while a sample is in flight is ignored. It produces no output pulse and does not advance any delay element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_i | input | DW | Signed current-error sample |
| err_stb_i | input | 1 | Sample strobe |
| cfg_we_i | input | 1 | Coefficient write enable (shadow bank) |
| cfg_addr_i | input | $clog2(8) | Coefficient address |
| cfg_wdata_i | input | CW | Signed coefficient value |
| swap_req_i | input | 1 | Request to exchange the bank roles |
| ctl_o | output | DW | Saturated control word |
| ctl_vld_o | output | 1 | One-cycle pulse when ctl_o is updated |
| bank_sel_o | output | 1 | Index of the bank in use |

## Verification
A swap request and a sample can fall in the same cycle, either together with the strobe or one cycle later while the sample is still in flight. The bench raises the swap request at each of these two points. The scoreboard expects that sample to use the old coefficients throughout, and expects bank_sel_o to change only after the sample finishes. The samples that follow are judged against a model that keeps its delay history across the swap.

// File: rtl/dbq_pkg.sv
package dbq_pkg;
  localparam int NCOEF  = 8;
  localparam int IDX_B0 = 0;
  localparam int IDX_B1 = 1;
  localparam int IDX_B2 = 2;
  localparam int IDX_A1 = 3;
  localparam int IDX_A2 = 4;
  localparam int IDX_C0 = 5;
  localparam int IDX_C1 = 6;
  localparam int IDX_D1 = 7;

  typedef logic signed [63:0] wide_t;

  // scale a product sum back by frac bits (floor) and clamp to width bits
  function automatic wide_t dbq_scale_sat(input wide_t acc, input int frac, input int width);
    wide_t sh;
    wide_t hi;
    wide_t lo;
    sh = acc >>> frac;
    hi = (wide_t'(1) <<< (width - 1)) - wide_t'(1);
    lo = -hi - wide_t'(1);
    if (sh > hi) return hi;
    if (sh < lo) return lo;
    return sh;
  endfunction
endpackage

// File: rtl/dbq_bank_ctl.sv
module dbq_bank_ctl
  import dbq_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en_i,
  input  logic [AW-1:0]            wr_addr_i,
  input  logic [CW-1:0]            wr_data_i,
  input  logic                     swap_req_i,
  input  logic                     hold_i,
  output logic                     act_o,
  output logic                     swap_apply_o,
  output logic [NCOEF-1:0][CW-1:0] coef_o
);
  logic [CW-1:0] bank_q [2][NCOEF];
  logic          act_q;
  logic          pend_q;
  logic          want;

  assign want         = pend_q | swap_req_i;
  assign swap_apply_o = want & ~hold_i;
  assign act_o        = act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= want & ~swap_apply_o;
      if (swap_apply_o) act_q <= ~act_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int k = 0; k < NCOEF; k++)
          bank_q[b][k] <= '0;
    end else if (wr_en_i && (int'(wr_addr_i) < NCOEF)) begin
      bank_q[~act_q][wr_addr_i] <= wr_data_i;
    end
  end

  for (genvar k = 0; k < NCOEF; k++) begin : g_sel
    assign coef_o[k] = bank_q[act_q][k];
  end

  assert_write_shadow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !swap_apply_o) |=> $stable(coef_o));
  assert_swap_now_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_req_i && !hold_i) |=> (act_q != $past(act_q)));
  assert_swap_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (act_q == $past(act_q)));
endmodule

// File: rtl/dbq_sos2.sv
module dbq_sos2
  import dbq_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [CW-1:0] b0_i,
  input  logic signed [CW-1:0] b1_i,
  input  logic signed [CW-1:0] b2_i,
  input  logic signed [CW-1:0] a1_i,
  input  logic signed [CW-1:0] a2_i,
  output logic signed [DW-1:0] w_o
);
  logic signed [DW-1:0] x1_q, x2_q, w1_q, w2_q;
  logic signed [DW-1:0] w_next;
  wide_t                acc;

  always_comb begin
    acc = wide_t'(b0_i) * wide_t'(x_i)
        + wide_t'(b1_i) * wide_t'(x1_q)
        + wide_t'(b2_i) * wide_t'(x2_q)
        - wide_t'(a1_i) * wide_t'(w1_q)
        - wide_t'(a2_i) * wide_t'(w2_q);
    w_next = DW'(dbq_scale_sat(acc, FRAC, DW));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x1_q <= '0;
      x2_q <= '0;
      w1_q <= '0;
      w2_q <= '0;
    end else if (start_i) begin
      x1_q <= x_i;
      x2_q <= x1_q;
      w1_q <= w_next;
      w2_q <= w1_q;
    end
  end

  assign w_o = w1_q;

  assert_hist_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(w1_q) && $stable(w2_q) && $stable(x1_q) && $stable(x2_q)));
endmodule

// File: rtl/dbq_sos1.sv
module dbq_sos1
  import dbq_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step_i,
  input  logic signed [DW-1:0] s_i,
  input  logic signed [CW-1:0] c0_i,
  input  logic signed [CW-1:0] c1_i,
  input  logic signed [CW-1:0] d1_i,
  output logic signed [DW-1:0] y_o,
  output logic                 vld_o
);
  logic signed [DW-1:0] sp_q, y_q;
  logic signed [DW-1:0] y_next;
  logic                 vld_q;
  wide_t                acc;

  always_comb begin
    acc = wide_t'(c0_i) * wide_t'(s_i)
        + wide_t'(c1_i) * wide_t'(sp_q)
        - wide_t'(d1_i) * wide_t'(y_q);
    y_next = DW'(dbq_scale_sat(acc, FRAC, DW));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= '0;
      y_q   <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= step_i;
      if (step_i) begin
        sp_q <= s_i;
        y_q  <= y_next;
      end
    end
  end

  assign y_o   = y_q;
  assign vld_o = vld_q;

  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> ($stable(y_q) && $stable(sp_q)));
endmodule

// File: rtl/dbq_comp.sv
module dbq_comp
  import dbq_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 14,
  localparam int AW  = $clog2(NCOEF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] err_i,
  input  logic          err_stb_i,
  input  logic          cfg_we_i,
  input  logic [AW-1:0] cfg_addr_i,
  input  logic [CW-1:0] cfg_wdata_i,
  input  logic          swap_req_i,
  output logic [DW-1:0] ctl_o,
  output logic          ctl_vld_o,
  output logic          bank_sel_o
);
  logic                     busy_q;
  logic                     accept;
  logic                     hold;
  logic                     swap_apply;
  logic [NCOEF-1:0][CW-1:0] coef;
  logic signed [DW-1:0]     stage1_w;
  logic signed [DW-1:0]     stage2_y;

  assign accept = err_stb_i & ~busy_q;
  assign hold   = busy_q | accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= accept;
  end

  dbq_bank_ctl #(.CW(CW), .AW(AW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(cfg_we_i), .wr_addr_i(cfg_addr_i), .wr_data_i(cfg_wdata_i),
    .swap_req_i(swap_req_i), .hold_i(hold),
    .act_o(bank_sel_o), .swap_apply_o(swap_apply), .coef_o(coef)
  );

  dbq_sos2 #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_s2 (
    .clk(clk), .rst_n(rst_n), .start_i(accept), .x_i($signed(err_i)),
    .b0_i($signed(coef[IDX_B0])), .b1_i($signed(coef[IDX_B1])),
    .b2_i($signed(coef[IDX_B2])), .a1_i($signed(coef[IDX_A1])),
    .a2_i($signed(coef[IDX_A2])), .w_o(stage1_w)
  );

  dbq_sos1 #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_s1 (
    .clk(clk), .rst_n(rst_n), .step_i(busy_q), .s_i(stage1_w),
    .c0_i($signed(coef[IDX_C0])), .c1_i($signed(coef[IDX_C1])),
    .d1_i($signed(coef[IDX_D1])), .y_o(stage2_y), .vld_o(ctl_vld_o)
  );

  assign ctl_o = stage2_y;

  assert_vld_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ##1 ctl_vld_o);
  assert_vld_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> ctl_vld_o);
  assert_busy_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> !busy_q);
  assert_no_swap_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !swap_apply);
endmodule

// File: tb/sim_dbq_comp.sv
`timescale 1ns/1ps
module sim_dbq_comp;
  localparam int DW = 16, CW = 16, FRAC = 14;
  localparam time CYC = 8ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] err_i = '0;
  logic          err_stb_i = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [2:0]    cfg_addr_i = '0;
  logic [CW-1:0] cfg_wdata_i = '0;
  logic          swap_req_i = 1'b0;
  logic [DW-1:0] ctl_o;
  logic          ctl_vld_o;
  logic          bank_sel_o;

  always #(CYC/2) clk = ~clk;

  dbq_comp #(.DW(DW), .CW(CW), .FRAC(FRAC)) u0 (
    .clk(clk), .rst_n(rst_n), .err_i(err_i), .err_stb_i(err_stb_i),
    .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .swap_req_i(swap_req_i), .ctl_o(ctl_o), .ctl_vld_o(ctl_vld_o),
    .bank_sel_o(bank_sel_o)
  );

  int n_cmp = 0, n_bad = 0;
  longint exp_q[$];
  string  tag_q[$];

  // reference model
  longint mb [2][8];
  int     mact = 0;
  longint mx1 = 0, mx2 = 0, mw1 = 0, mw2 = 0, msp = 0, my = 0;

  function automatic longint m_fix(input longint v);
    longint q;
    q = v / 16384;
    if (v < 0 && q * 16384 != v) q = q - 1;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return q;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (rst_n && ctl_vld_o) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R9: unexpected output pulse got %0d expected none",
                 $signed(ctl_o));
      end else begin
        longint e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, longint'($signed(ctl_o)), e);
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_addr_i = 3'(a); cfg_wdata_i = CW'(d);
    @(negedge clk);
    cfg_we_i = 1'b0;
    mb[1 - mact][a] = longint'(d);
  endtask

  task automatic do_swap();
    @(negedge clk);
    swap_req_i = 1'b1;
    @(negedge clk);
    swap_req_i = 1'b0;
    mact = 1 - mact;
  endtask

  function automatic longint model_step(input longint x);
    longint w, y, acc;
    acc = mb[mact][0]*x + mb[mact][1]*mx1 + mb[mact][2]*mx2
        - mb[mact][3]*mw1 - mb[mact][4]*mw2;
    w = m_fix(acc);
    mx2 = mx1; mx1 = x; mw2 = mw1; mw1 = w;
    acc = mb[mact][5]*w + mb[mact][6]*msp - mb[mact][7]*my;
    y = m_fix(acc);
    msp = w; my = y;
    return y;
  endfunction

  // swap_mode: 0 none, 1 with strobe, 2 one cycle later
  task automatic send(input int x, input int swap_mode, input string tag);
    exp_q.push_back(model_step(longint'(x)));
    tag_q.push_back(tag);
    @(negedge clk);
    err_i = DW'(x); err_stb_i = 1'b1; swap_req_i = (swap_mode == 1);
    @(negedge clk);
    err_stb_i = 1'b0; swap_req_i = (swap_mode == 2);
    @(negedge clk);
    swap_req_i = 1'b0;
    @(negedge clk);
    if (swap_mode != 0) mact = 1 - mact;
  endtask

  initial begin
    #(CYC * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < 8; k++) mb[b][k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ctl_o reset", longint'(ctl_o), 0);
    check("R1 ctl_vld_o reset", longint'(ctl_vld_o), 0);
    check("R1 bank_sel_o reset", longint'(bank_sel_o), 0);

    // R4: load shadow bank 1 with a pass-through; bank 0 stays zero
    wr(0, 16384);
    wr(5, 16384);
    send(1000, 0, "R4 shadow write ignored");
    check("R4 bank_sel unchanged", longint'(bank_sel_o), 0);

    // R5: idle swap
    do_swap();
    @(negedge clk);
    check("R5 bank_sel after swap", longint'(bank_sel_o), 1);
    send(1000, 0, "R5 new bank pass");
    send(-2000, 0, "R2 negative pass");

    // bank 0 (shadow) gets a filter with history terms
    wr(0, 8192); wr(1, 4096); wr(2, -2048); wr(3, -8192); wr(4, 2048);
    wr(5, 12288); wr(6, 4096); wr(7, -4096);
    send(3000, 0, "R4 bank1 still active");

    // R6: swap with the strobe
    send(500, 1, "R6 swap with strobe old bank");
    check("R6 bank_sel after held swap", longint'(bank_sel_o), 0);
    // R7: history carried into bank 0
    send(1500, 0, "R7 history kept R2");
    send(-700, 0, "R3 first-order stage");
    send(4000, 0, "R2 biquad recursion");

    // R6: swap while in flight
    send(-1200, 2, "R6 swap in flight old bank");
    check("R6 bank_sel after in-flight swap", longint'(bank_sel_o), 1);
    send(2500, 0, "R7 history kept after swap");

    // R8: saturation, bank 0 made large
    wr(0, 32767); wr(1, 0); wr(2, 0); wr(3, 0); wr(4, 0);
    wr(5, 32767); wr(6, 0); wr(7, 0);
    do_swap();
    @(negedge clk);
    check("R5 bank_sel second swap", longint'(bank_sel_o), 0);
    send(30000, 0, "R8 positive saturation");
    send(-30000, 0, "R8 negative saturation");
    send(9000, 0, "R8 intermediate saturation");

    // R9: second strobe while busy is ignored
    exp_q.push_back(model_step(longint'(100)));
    tag_q.push_back("R9 first of double strobe");
    @(negedge clk);
    err_i = DW'(100); err_stb_i = 1'b1;
    @(negedge clk);
    err_i = DW'(-20000);
    @(negedge clk);
    err_stb_i = 1'b0;
    repeat (2) @(negedge clk);
    send(200, 0, "R9 ignored strobe left no history");

    repeat (3) @(negedge clk);
    check("R3 all outputs produced", longint'(exp_q.size()), 0);
    finish_run();
  end
endmodule